// File: doc/BRIEF.md
# Multiplexed Pixel Output Byte Formatter

The formatter sits at the output of a pixel processing chain. Each pixel arrives as a 12-bit sample with three kinds of status: a two-bit colour channel code, an out-of-range flag and a flag that gives the control-port mode. The block presents the pixel in one of three formats. It can drive the full 12-bit word for one clock. It can split the pixel over two clocks as two bytes on the upper eight bits of the output bus. It can stretch the pixel over three clocks, with the first byte held for two of them. In every byte format the second byte packs the four low sample bits together with the three status items.

A single sequencer holds the state. `ST_IDLE` means no pixel is on the bus. `ST_WIDE` is the single period of a full-word pixel. `ST_HI_A` is the first period of the first byte. `ST_HI_B` is the repeated first-byte period, used only in the three-period format. `ST_LO` is the second-byte period.

The sequencer has these transitions:
- From `ST_IDLE`, `ST_WIDE` or `ST_LO`, an accepted strobe goes to `ST_WIDE` when the format select is the full-word code, and to `ST_HI_A` when it is a byte format. With no strobe these states go to `ST_IDLE`.
- `ST_HI_A` goes to `ST_HI_B` when the format captured with the pixel is the three-period one. Otherwise it goes to `ST_LO`.
- `ST_HI_B` always goes to `ST_LO`.

The sample, the flags and the format are registered when a strobe is accepted. Later changes on those inputs do not alter a pixel already in progress. A phase output tells a downstream receiver which period is on the bus.

Top module: `pix_byte_fmt`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_bus` is zero and `byte_phase` is 0.
- R2: With `fmt_sel` = 00, an accepted pixel appears in the following cycle as `out_bus` = sample with `byte_phase` = 1, for exactly one cycle. Code 11 behaves exactly as 00.
- R3: With `fmt_sel` = 01, the cycle after acceptance shows `out_bus[11:4]` = sample[11:4] with `byte_phase` = 1. The next cycle shows `out_bus[11:4]` = {sample[3:0], par_port, chan_code[1], chan_code[0], range_err} with `byte_phase` = 3. `par_port` is 1 for parallel and 0 for serial. The channel codes are 00 red, 01 green and 10 blue. `range_err` is 1 when the pixel is out of range.
- R4: With `fmt_sel` = 10, the pixel occupies three cycles. The first two carry the first byte, with `byte_phase` 1 and then 2. The third carries the second byte, with `byte_phase` 3.
- R5: In the byte formats, `out_bus[3:0]` is zero.
- R6: The sample, flags and format are taken in the cycle of acceptance. Changes to them during the pixel's remaining periods have no effect on its output.
- R7: `pix_vld` is accepted only in `ST_IDLE`, `ST_WIDE` or `ST_LO`. A strobe during `ST_HI_A` or `ST_HI_B` is ignored.
- R8: A strobe in the last period of a pixel starts the next pixel in the following cycle with no gap. Without such a strobe, the bus returns to zero with `byte_phase` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_vld | input | 1 | Pixel strobe |
| pix_data | input | 12 | Pixel sample |
| chan_code | input | 2 | Channel code (00 red, 01 green, 10 blue) |
| range_err | input | 1 | Out-of-range flag |
| par_port | input | 1 | Control-port mode flag (1 parallel, 0 serial) |
| fmt_sel | input | 2 | Output format (00/11 word, 01 two-byte, 10 three-period) |
| out_bus | output | 12 | Output bus; bytes on bits 11:4 |
| byte_phase | output | 2 | 0 none, 1 first byte or word, 2 repeated first byte, 3 second byte |

## Verification
The hardest situations to reach are strobes and input changes that land inside a pixel that is already in progress, because they only matter on the exact cycles of `ST_HI_A` and `ST_HI_B`. The stimulus drives a second strobe, with a different sample, a different format and different flags, during those periods. It then checks that the second byte still belongs to the first pixel and that the bus goes idle afterwards. A separate sequence strobes on the `ST_LO` period to confirm that pixels follow each other without a gap.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
    typedef enum logic [1:0] {
        FMT_WIDE   = 2'b00,
        FMT_PAIR   = 2'b01,
        FMT_TRIPLE = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIDE,
        ST_HI_A,
        ST_HI_B,
        ST_LO
    } st_e;

    localparam logic [1:0] PH_NONE   = 2'd0;
    localparam logic [1:0] PH_FIRST  = 2'd1;
    localparam logic [1:0] PH_REPEAT = 2'd2;
    localparam logic [1:0] PH_SECOND = 2'd3;
endpackage

// File: rtl/pbf_seq.sv
module pbf_seq
    import pbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_vld,
    input  logic [1:0] fmt_sel,
    output st_e        state,
    output logic       accept
);
    st_e  state_nx;
    logic triple_q;
    logic is_byte_fmt;

    assign is_byte_fmt = (fmt_sel == FMT_PAIR) || (fmt_sel == FMT_TRIPLE);

    // acceptance window: idle or final period of a pixel (R7)
    always_comb begin
        unique case (state)
            ST_IDLE, ST_WIDE, ST_LO: accept = pix_vld;
            default:                 accept = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_WIDE, ST_LO: begin
                if (pix_vld) state_nx = is_byte_fmt ? ST_HI_A : ST_WIDE;
                else         state_nx = ST_IDLE;
            end
            ST_HI_A: state_nx = triple_q ? ST_HI_B : ST_LO;
            ST_HI_B: state_nx = ST_LO;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            triple_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) triple_q <= (fmt_sel == FMT_TRIPLE);
        end
    end

    a_r4_triple_repeats: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI_A && triple_q) |=> (state == ST_HI_B));
    a_r3_pair_second: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI_A && !triple_q) |=> (state == ST_LO));
    a_r7_repeat_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI_B) |=> (state == ST_LO));
    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LO || state == ST_WIDE) && !pix_vld) |=> (state == ST_IDLE));
endmodule

// File: rtl/pbf_capture.sv
module pbf_capture #(
    parameter int DATA_W = 12,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] pix_data,
    input  logic [CH_W-1:0]   chan_code,
    input  logic              range_err,
    input  logic              par_port,
    output logic [DATA_W-1:0] data_q,
    output logic [CH_W-1:0]   ch_q,
    output logic              rng_q,
    output logic              par_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ch_q   <= '0;
            rng_q  <= 1'b0;
            par_q  <= 1'b0;
        end else if (load) begin
            data_q <= pix_data;
            ch_q   <= chan_code;
            rng_q  <= range_err;
            par_q  <= par_port;
        end
    end
endmodule

// File: rtl/pbf_mux.sv
module pbf_mux
    import pbf_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8,
    parameter int CH_W   = 2
) (
    input  st_e               state,
    input  logic [DATA_W-1:0] data_q,
    input  logic [CH_W-1:0]   ch_q,
    input  logic              rng_q,
    input  logic              par_q,
    output logic [DATA_W-1:0] out_bus,
    output logic [1:0]        byte_phase
);
    localparam int PAD_W = DATA_W - BYTE_W;
    localparam int LOW_W = BYTE_W - CH_W - 2;

    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] lo_byte;

    assign hi_byte = data_q[DATA_W-1 -: BYTE_W];
    assign lo_byte = {data_q[LOW_W-1:0], par_q, ch_q, rng_q};

    always_comb begin
        unique case (state)
            ST_WIDE: begin
                out_bus    = data_q;
                byte_phase = PH_FIRST;
            end
            ST_HI_A: begin
                out_bus    = {hi_byte, {PAD_W{1'b0}}};
                byte_phase = PH_FIRST;
            end
            ST_HI_B: begin
                out_bus    = {hi_byte, {PAD_W{1'b0}}};
                byte_phase = PH_REPEAT;
            end
            ST_LO: begin
                out_bus    = {lo_byte, {PAD_W{1'b0}}};
                byte_phase = PH_SECOND;
            end
            default: begin
                out_bus    = '0;
                byte_phase = PH_NONE;
            end
        endcase
    end
endmodule

// File: rtl/pix_byte_fmt.sv
module pix_byte_fmt
    import pbf_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_vld,
    input  logic [DATA_W-1:0] pix_data,
    input  logic [CH_W-1:0]   chan_code,
    input  logic              range_err,
    input  logic              par_port,
    input  logic [1:0]        fmt_sel,
    output logic [DATA_W-1:0] out_bus,
    output logic [1:0]        byte_phase
);
    localparam int PAD_W = DATA_W - BYTE_W;

    st_e               state;
    logic              accept;
    logic [DATA_W-1:0] data_q;
    logic [CH_W-1:0]   ch_q;
    logic              rng_q;
    logic              par_q;

    pbf_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_vld (pix_vld),
        .fmt_sel (fmt_sel),
        .state   (state),
        .accept  (accept)
    );

    pbf_capture #(.DATA_W(DATA_W), .CH_W(CH_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .pix_data  (pix_data),
        .chan_code (chan_code),
        .range_err (range_err),
        .par_port  (par_port),
        .data_q    (data_q),
        .ch_q      (ch_q),
        .rng_q     (rng_q),
        .par_q     (par_q)
    );

    pbf_mux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CH_W(CH_W)) u_mux (
        .state      (state),
        .data_q     (data_q),
        .ch_q       (ch_q),
        .rng_q      (rng_q),
        .par_q      (par_q),
        .out_bus    (out_bus),
        .byte_phase (byte_phase)
    );

    a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_phase == PH_NONE) |-> (out_bus == '0));
    a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_phase == PH_SECOND || byte_phase == PH_REPEAT) |-> (out_bus[PAD_W-1:0] == '0));
    a_r6_repeat_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_phase == PH_REPEAT) |-> $stable(out_bus));
endmodule

// File: tb/pix_byte_fmt_tb.sv
module pix_byte_fmt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_vld = 1'b0;
    logic [11:0] pix_data = '0;
    logic [1:0]  chan_code = '0;
    logic        range_err = 1'b0;
    logic        par_port = 1'b0;
    logic [1:0]  fmt_sel = '0;
    logic [11:0] out_bus;
    logic [1:0]  byte_phase;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pix_byte_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_data(pix_data),
        .chan_code(chan_code), .range_err(range_err), .par_port(par_port),
        .fmt_sel(fmt_sel), .out_bus(out_bus), .byte_phase(byte_phase)
    );

    task automatic chk(input string req, input logic [11:0] exp_bus, input logic [1:0] exp_ph);
        n_vec++;
        if (out_bus !== exp_bus || byte_phase !== exp_ph) begin
            n_bad++;
            $display("FAIL %s: bus=%h phase=%0d expected bus=%h phase=%0d",
                     req, out_bus, byte_phase, exp_bus, exp_ph);
        end
    endtask

    task automatic drive(input logic v, input logic [11:0] d, input logic [1:0] c,
                         input logic r, input logic p, input logic [1:0] f);
        pix_vld = v; pix_data = d; chan_code = c; range_err = r; par_port = p; fmt_sel = f;
    endtask

    function automatic logic [11:0] hi_of(input logic [11:0] d);
        return {d[11:4], 4'b0};
    endfunction

    function automatic logic [11:0] lo_of(input logic [11:0] d, input logic p,
                                          input logic [1:0] c, input logic r);
        return {d[3:0], p, c, r, 4'b0};
    endfunction

    task automatic t_reset;
        @(negedge clk); chk("R1 in reset", 12'h000, 2'd0);
        rst_n = 1'b1;
        @(negedge clk); chk("R1 after release", 12'h000, 2'd0);
    endtask

    task automatic t_wide;
        drive(1, 12'hA5C, 2'b01, 1, 1, 2'b00);
        @(negedge clk); drive(0, 12'h000, 0, 0, 0, 2'b00);
        chk("R2 wide word", 12'hA5C, 2'd1);
        @(negedge clk); chk("R8 idle after wide", 12'h000, 2'd0);
        drive(1, 12'h3E7, 2'b10, 0, 0, 2'b11);
        @(negedge clk); drive(1, 12'h812, 2'b00, 0, 0, 2'b00);
        chk("R2 reserved code as wide", 12'h3E7, 2'd1);
        @(negedge clk); drive(0, 0, 0, 0, 0, 2'b00);
        chk("R8 wide back-to-back", 12'h812, 2'd1);
        @(negedge clk); chk("R8 idle", 12'h000, 2'd0);
    endtask

    task automatic t_pair;
        drive(1, 12'hB6D, 2'b10, 1, 1, 2'b01);
        @(negedge clk);
        chk("R3 first byte", hi_of(12'hB6D), 2'd1);
        drive(1, 12'h0F0, 2'b01, 0, 0, 2'b00);   // R7/R6: ignored mid-pixel
        @(negedge clk); drive(0, 0, 0, 0, 0, 2'b00);
        chk("R3 R5 R6 second byte blue/parallel/range", lo_of(12'hB6D, 1, 2'b10, 1), 2'd3);
        @(negedge clk); chk("R7 mid-pixel strobe ignored", 12'h000, 2'd0);
        drive(1, 12'h249, 2'b00, 0, 0, 2'b01);
        @(negedge clk); drive(0, 0, 0, 0, 0, 2'b01);
        chk("R3 first byte red", hi_of(12'h249), 2'd1);
        @(negedge clk);
        chk("R3 second byte red/serial", lo_of(12'h249, 0, 2'b00, 0), 2'd3);
        drive(1, 12'hC37, 2'b01, 0, 1, 2'b01);
        @(negedge clk); drive(0, 0, 0, 0, 0, 2'b00);
        chk("R8 pair back-to-back", hi_of(12'hC37), 2'd1);
        @(negedge clk); chk("R3 second byte green", lo_of(12'hC37, 1, 2'b01, 0), 2'd3);
        @(negedge clk); chk("R8 idle after pair", 12'h000, 2'd0);
    endtask

    task automatic t_triple;
        drive(1, 12'h5A1, 2'b01, 1, 0, 2'b10);
        @(negedge clk);
        chk("R4 first period", hi_of(12'h5A1), 2'd1);
        drive(1, 12'hFFF, 2'b10, 0, 1, 2'b01);   // R6/R7: ignored
        @(negedge clk);
        chk("R4 R6 repeated first byte", hi_of(12'h5A1), 2'd2);
        drive(1, 12'h777, 2'b00, 0, 1, 2'b00);   // R7: ignored in repeat period
        @(negedge clk); drive(0, 0, 0, 0, 0, 2'b00);
        chk("R4 R5 third period second byte", lo_of(12'h5A1, 0, 2'b01, 1), 2'd3);
        @(negedge clk); chk("R7 idle after triple", 12'h000, 2'd0);
    endtask

    initial begin
        t_reset();
        t_wide();
        t_pair();
        t_triple();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule